// File: doc/BRIEF.md
# Receive Sync Position Pulse Generator

This block drives one digital pin that tells downstream logic two things about a line receiver. Until the receive deframer reports frame lock, the pin stays high and acts as a "not yet locked" flag. Once lock is held, the pin idles low. It then rises for exactly one line-bit period each time the deframer marks the received sync bit. A system that needs to align its own timing to the far end can read the pulse's leading edge as the arrival time of the sync bit.

The pulse width is a count of system clock cycles for one line bit. One count applies at the fast line rate (160 kb/s) and another at the slow rate (80 kb/s). The rate input picks the count when the pulse starts. In modem mode the pin is unused and is driven low. A status bit gives the registered lock flag.

Top module: `rxsp_gen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `sync_pin` is 1 and `lock_stat` is 0.
- R2: In network mode (`mode_modem`=0), when `frame_lock` is 0 at an edge, `sync_pin` is 1 after that edge.
- R3: `lock_stat` equals the value `frame_lock` had at the previous clock edge.
- R4: In network mode, a start condition at an edge sets `sync_pin` to 1 after that edge. The start condition is `frame_mark`=1, `bit_stb`=1, `frame_lock`=1 and `lock_stat`=1.
- R5: With `rate_fast`=1 when the pulse starts, `sync_pin` stays high for exactly FAST_CYC cycles and then returns low.
- R6: With `rate_fast`=0 when the pulse starts, `sync_pin` stays high for exactly SLOW_CYC cycles and then returns low.
- R7: No pulse starts on the edge where `frame_lock` is 1 but `lock_stat` is still 0. `sync_pin` is 0 after that edge.
- R8: When `mode_modem` is 1 at an edge, `sync_pin` is 0 after that edge, whatever the lock state is.
- R9: If lock drops during a pulse, `sync_pin` is high after that edge. The rest of the pulse is discarded, so after relock the pin is low until the next start.
- R10: A `frame_mark` without `bit_stb` starts no pulse.
- R11: A start condition during a pulse restarts the width count, so the pin stays high for a full width after the new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_fast | input | 1 | 1 selects the 160 kb/s line rate, 0 selects 80 kb/s |
| mode_modem | input | 1 | 1 selects modem mode (pin forced low), 0 selects network mode |
| bit_stb | input | 1 | One-cycle strobe for each recovered line bit |
| frame_mark | input | 1 | Deframer marks the received sync bit position |
| frame_lock | input | 1 | Deframer reports receive frame lock |
| sync_pin | output | 1 | Not-locked flag, or sync position pulse |
| lock_stat | output | 1 | Registered lock status (1 = synchronized) |

## Verification
A counter stuck or loaded with the wrong width shows up as a pulse that is too long or too short. This appears within one bit period of the first sync mark, at either rate. A lock register out of step with `frame_lock` produces a spurious pulse on the edge where lock rises, or a missing pulse on the first locked mark. Either shows at the port on the next cycle. A timer state that survives a lock loss shows as a high pin after relock without a mark.

// File: rtl/rxsp_pkg.sv
package rxsp_pkg;

    typedef enum logic {
        MODE_NET   = 1'b0,
        MODE_MODEM = 1'b1
    } rxsp_mode_e;

    typedef enum logic [1:0] {
        PIN_IDLE    = 2'd0,
        PIN_UNLOCK  = 2'd1,
        PIN_PULSE   = 2'd2,
        PIN_FORCED  = 2'd3
    } rxsp_pin_e;

    typedef struct packed {
        logic locked;
        logic rising;
        logic start;
    } rxsp_lock_t;

    function automatic int unsigned rxsp_cnt_w(input int unsigned max_cyc);
        return (max_cyc < 2) ? 1 : $clog2(max_cyc + 1);
    endfunction

    function automatic int unsigned rxsp_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rxsp_lock_track.sv
module rxsp_lock_track
    import rxsp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_lock,
    input  logic       frame_mark,
    input  logic       bit_stb,
    output rxsp_lock_t lock_info
);
    logic lock_q;

    always_ff @(posedge clk) begin
        if (rst) lock_q <= 1'b0;
        else     lock_q <= frame_lock;
    end

    always_comb begin
        lock_info.locked = lock_q;
        lock_info.rising = frame_lock & ~lock_q;
        lock_info.start  = frame_lock & lock_q & frame_mark & bit_stb;
    end
endmodule

// File: rtl/rxsp_width_sel.sv
module rxsp_width_sel #(
    parameter int unsigned FAST_CYC = 625,
    parameter int unsigned SLOW_CYC = 1250,
    parameter int unsigned CNT_W    = 11
) (
    input  logic             rate_fast,
    output logic [CNT_W-1:0] load_val
);
    localparam logic [CNT_W-1:0] FAST_LOAD = CNT_W'(FAST_CYC - 1);
    localparam logic [CNT_W-1:0] SLOW_LOAD = CNT_W'(SLOW_CYC - 1);

    generate
        if (FAST_CYC == SLOW_CYC) begin : g_single
            logic unused_rate;
            assign unused_rate = rate_fast;
            assign load_val    = FAST_LOAD;
        end else begin : g_dual
            assign load_val = rate_fast ? FAST_LOAD : SLOW_LOAD;
        end
    endgenerate
endmodule

// File: rtl/rxsp_pulse_timer.sv
module rxsp_pulse_timer
    import rxsp_pkg::*;
#(
    parameter int unsigned CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_modem,
    input  logic             frame_lock,
    input  rxsp_lock_t       lock_info,
    input  logic [CNT_W-1:0] load_val,
    output logic             pin_q,
    output rxsp_pin_e        pin_state
);
    logic [CNT_W-1:0] rem_q;
    logic [CNT_W-1:0] rem_d;
    rxsp_pin_e        state_d;

    always_comb begin
        rem_d = '0;
        if (rxsp_mode_e'(mode_modem) == MODE_MODEM) begin
            state_d = PIN_FORCED;
        end else if (!frame_lock) begin
            state_d = PIN_UNLOCK;
        end else if (lock_info.start) begin
            state_d = PIN_PULSE;
            rem_d   = load_val;
        end else if (rem_q != '0) begin
            state_d = PIN_PULSE;
            rem_d   = rem_q - 1'b1;
        end else begin
            state_d = PIN_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q     <= '0;
            pin_state <= PIN_UNLOCK;
            pin_q     <= 1'b1;
        end else begin
            rem_q     <= rem_d;
            pin_state <= state_d;
            pin_q     <= (state_d == PIN_UNLOCK) || (state_d == PIN_PULSE);
        end
    end
endmodule

// File: rtl/rxsp_gen.sv
module rxsp_gen
    import rxsp_pkg::*;
#(
    parameter int unsigned FAST_CYC = 625,
    parameter int unsigned SLOW_CYC = 1250
) (
    input  logic clk,
    input  logic rst,
    input  logic rate_fast,
    input  logic mode_modem,
    input  logic bit_stb,
    input  logic frame_mark,
    input  logic frame_lock,
    output logic sync_pin,
    output logic lock_stat
);
    localparam int unsigned CNT_W = rxsp_cnt_w(rxsp_max(FAST_CYC, SLOW_CYC));

    rxsp_lock_t       lock_info;
    logic [CNT_W-1:0] load_val;
    rxsp_pin_e        pin_state;
    logic             unused_state;

    rxsp_lock_track u_lock (
        .clk        (clk),
        .rst        (rst),
        .frame_lock (frame_lock),
        .frame_mark (frame_mark),
        .bit_stb    (bit_stb),
        .lock_info  (lock_info)
    );

    rxsp_width_sel #(
        .FAST_CYC (FAST_CYC),
        .SLOW_CYC (SLOW_CYC),
        .CNT_W    (CNT_W)
    ) u_width (
        .rate_fast (rate_fast),
        .load_val  (load_val)
    );

    rxsp_pulse_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .mode_modem (mode_modem),
        .frame_lock (frame_lock),
        .lock_info  (lock_info),
        .load_val   (load_val),
        .pin_q      (sync_pin),
        .pin_state  (pin_state)
    );

    assign lock_stat    = lock_info.locked;
    assign unused_state = ^{pin_state, lock_info.rising};
endmodule

// File: rtl/rxsp_gen_chk.sv
module rxsp_gen_chk (
    input logic clk,
    input logic rst,
    input logic mode_modem,
    input logic bit_stb,
    input logic frame_mark,
    input logic frame_lock,
    input logic sync_pin,
    input logic lock_stat
);
    assert_unlock_high_R2: assert property (@(posedge clk) disable iff (rst)
        (!mode_modem && !frame_lock) |=> sync_pin);

    assert_stat_follow_R3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (lock_stat == $past(frame_lock)));

    assert_start_high_R4: assert property (@(posedge clk) disable iff (rst)
        (!mode_modem && frame_lock && lock_stat && frame_mark && bit_stb) |=> sync_pin);

    assert_no_rise_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        (!mode_modem && frame_lock && !lock_stat) |=> !sync_pin);

    assert_modem_low_R8: assert property (@(posedge clk) disable iff (rst)
        mode_modem |=> !sync_pin);
endmodule

bind rxsp_gen rxsp_gen_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode_modem (mode_modem),
    .bit_stb    (bit_stb),
    .frame_mark (frame_mark),
    .frame_lock (frame_lock),
    .sync_pin   (sync_pin),
    .lock_stat  (lock_stat)
);

// File: tb/rxsp_gen_tb.sv
module rxsp_gen_tb;
    localparam int FAST = 6;
    localparam int SLOW = 12;
    localparam int NVEC = 15;

    // fields: {modem, rate_fast, lock, mark, stb, exp_sync, exp_stat}
    localparam logic [6:0] VEC [NVEC] = '{
        7'b0100010, 7'b0111101, 7'b0110001, 7'b0111001, 7'b0111111,
        7'b0110011, 7'b0110011, 7'b0110011, 7'b0110011, 7'b0110011,
        7'b0110001, 7'b0100010, 7'b0110001, 7'b1111101, 7'b1100000
    };

    logic clk = 1'b0;
    logic rst, rate_fast, mode_modem, bit_stb, frame_mark, frame_lock;
    logic sync_pin, lock_stat;
    int   n_chk = 0;
    int   n_bad = 0;

    always #5 clk = ~clk;

    rxsp_gen #(.FAST_CYC(FAST), .SLOW_CYC(SLOW)) u_dut (
        .clk(clk), .rst(rst), .rate_fast(rate_fast), .mode_modem(mode_modem),
        .bit_stb(bit_stb), .frame_mark(frame_mark), .frame_lock(frame_lock),
        .sync_pin(sync_pin), .lock_stat(lock_stat)
    );

    function automatic string vec_tag(input int i);
        case (i)
            0, 11:  return "R2";
            1, 12:  return "R7";
            3:      return "R10";
            4:      return "R4";
            10:     return "R5";
            13, 14: return "R8";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic drive(input logic m, input logic r, input logic l,
                         input logic k, input logic s);
        @(negedge clk);
        mode_modem = m; rate_fast = r; frame_lock = l; frame_mark = k; bit_stb = s;
        @(posedge clk);
        #1;
    endtask

    task automatic count_pulse(input string tag, input logic r, input int w);
        for (int i = 0; i <= w; i++) begin
            if (i == 0) drive(1'b0, r, 1'b1, 1'b1, 1'b1);
            else        drive(1'b0, r, 1'b1, 1'b0, 1'b0);
            check(tag, sync_pin, (i < w) ? 1'b1 : 1'b0);
        end
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; rate_fast = 1'b1; mode_modem = 1'b0;
        bit_stb = 1'b0; frame_mark = 1'b0; frame_lock = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", sync_pin, 1'b1);
        check("R1", lock_stat, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R1", sync_pin, 1'b1);
        check("R1", lock_stat, 1'b0);

        // R2 R3 R4 R5 R7 R8 R10 table walk
        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2]);
            check(vec_tag(i), sync_pin, VEC[i][1]);
            check("R3", lock_stat, VEC[i][0]);
        end

        // relock, then slow-rate width R6
        drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R7", sync_pin, 1'b0);
        count_pulse("R6", 1'b0, SLOW);

        // fast-rate width again R5
        count_pulse("R5", 1'b1, FAST);

        // R9: lock lost mid-pulse, remainder discarded
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
        drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R9", sync_pin, 1'b1);
        drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R9", sync_pin, 1'b1);
        check("R9", lock_stat, 1'b0);
        drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R9", sync_pin, 1'b0);
        drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R9", sync_pin, 1'b0);

        // R11: retrigger during a pulse
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
        drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R11", sync_pin, 1'b1);
        count_pulse("R11", 1'b1, FAST);

        // R8: modem while locked and mid-pulse
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
        drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R8", sync_pin, 1'b0);
        check("R3", lock_stat, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule